// File: doc/BRIEF.md
# DMA Channel Source Address Bank

This block keeps the source address for each channel of a four-channel DMA engine. Every channel has a 26-bit live address, a shadow copy of the programmed start address, and a one-bit area select. The area select picks internal RAM or the external and peripheral space. A processor programs each channel through a 16-bit port that addresses one half-word at a time. The port can also read back the value that the register holds at that moment.

While a channel's enable is high, the transfer engine pulses a step strobe for each element it moves. The live address then advances by the element size, and the `fetch_addr` output always shows the address to use for the next fetch. For 16-bit elements, the fetch address has its least significant bit forced to zero, so a misaligned half-word access never reaches the bus. When the completion strobe arrives, the live address returns to the shadow value. The channel is then ready to run the same transfer again without being programmed a second time.

Top module: `dma_src_addr_bank`

## Requirements
- R1: During and right after reset, every live address, start address and area bit is zero, so all fetch addresses and all read data read as zero.
- R2: A write with `cpu_hi`=0 to a disabled channel loads `cpu_wdata` into address bits 15..0 of that channel's live and start addresses, and leaves every other channel unchanged.
- R3: A write with `cpu_hi`=1 to a disabled channel loads `cpu_wdata[9:0]` into address bits 25..16 and `cpu_wdata[15]` into the area bit. `cpu_wdata[14:10]` is discarded. A high-half read returns {area, 5'b0, address[25:16]}.
- R4: Writes to a channel whose enable is 1 change neither its live address, its start address nor its area bit.
- R5: A step strobe on an enabled channel advances the address by 1 when `xfer_wide`=0 and by 2 when `xfer_wide`=1, wrapping modulo 2^26.
- R6: When `xfer_wide`=1, `fetch_addr` has bit 0 cleared. A step from an odd live address adds 2 to the even-aligned address.
- R7: A completion strobe reloads the live address from the start address whatever the enable is, and it wins over a step or write in the same cycle.
- R8: While a transfer runs, a read returns the live address as it is now: a low-half read gives bits 15..0 and a high-half read gives bits 25..16, with no alignment applied.
- R9: A step strobe on a disabled channel has no effect, and strobes on one channel never change another channel.
- R10: `area_int` shows each channel's area bit, where 1 selects internal RAM and 0 selects external or peripheral space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Half-word write strobe |
| cpu_ch | input | 2 | Channel selected for read and write |
| cpu_hi | input | 1 | 1 selects the high half, 0 selects the low half |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the selected half (combinational) |
| ch_en | input | 4 | Channel enable, one bit per channel |
| xfer_step | input | 4 | Per-channel pulse that advances the address |
| xfer_wide | input | 4 | Per-channel element size, 1 for 16-bit and 0 for 8-bit |
| xfer_done | input | 4 | Per-channel completion pulse |
| fetch_addr | output | 104 | Packed per-channel fetch addresses, channel c at bits [26c+25:26c] |
| area_int | output | 4 | Per-channel area select |

## Verification
Any error in a live address appears on `fetch_addr` in the cycle after the faulty update, and it stays there until the next completion strobe. A corrupted start address stays hidden while a transfer runs. It only shows up one cycle after `xfer_done`, when the reload puts the wrong value on the outputs. That is why the bench drives a completion strobe after writes that were attempted during a transfer and after a sequence of steps. A wrong area bit or a wrong reserved field shows at once on a high-half read.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  localparam int unsigned DSA_NUM_CH = 4;
  localparam int unsigned DSA_ADDR_W = 26;
  localparam int unsigned DSA_HALF_W = 16;
endpackage

// File: rtl/dsa_channel.sv
module dsa_channel #(
  parameter int unsigned ADDR_W = dsa_pkg::DSA_ADDR_W,
  parameter int unsigned HALF_W = dsa_pkg::DSA_HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic              en,
  input  logic              step,
  input  logic              wide,
  input  logic              done,
  output logic [ADDR_W-1:0] live_o,
  output logic [ADDR_W-1:0] fetch_o,
  output logic              area_o
);
  localparam int unsigned HI_W = ADDR_W - HALF_W;

  logic [ADDR_W-1:0] live_q, live_d, start_q, start_d, fetch, inc;
  logic              area_q, area_d, load;

  // aligned fetch address and per-step increment
  always_comb begin
    fetch = wide ? {live_q[ADDR_W-1:1], 1'b0} : live_q;
    inc   = wide ? ADDR_W'(2) : ADDR_W'(1);
  end

  // next state: completion first, then stepping (enabled), then writes (disabled)
  always_comb begin
    live_d  = live_q;
    start_d = start_q;
    area_d  = area_q;
    if (done) begin
      live_d = start_q;
    end else if (en) begin
      if (step) live_d = fetch + inc;
    end else if (wr_lo) begin
      live_d[HALF_W-1:0]  = wdata;
      start_d[HALF_W-1:0] = wdata;
    end else if (wr_hi) begin
      live_d[ADDR_W-1:HALF_W]  = wdata[HI_W-1:0];
      start_d[ADDR_W-1:HALF_W] = wdata[HI_W-1:0];
      area_d                   = wdata[HALF_W-1];
    end
  end

  assign load = done | (en & step) | (~en & (wr_lo | wr_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      start_q <= '0;
      area_q  <= 1'b0;
    end else if (load) begin
      live_q  <= live_d;
      start_q <= start_d;
      area_q  <= area_d;
    end
  end

  assign live_o  = live_q;
  assign fetch_o = fetch;
  assign area_o  = area_q;

  // R7
  done_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> live_q == $past(start_q));
  // R5
  byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && !done && !wide) |=> live_q == ADDR_W'($past(live_q) + ADDR_W'(1)));
  // R4
  start_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(start_q) && $stable(area_q));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step && !done) |=> $stable(live_q));
endmodule

// File: rtl/dsa_rd_mux.sv
module dsa_rd_mux #(
  parameter int unsigned NUM_CH = dsa_pkg::DSA_NUM_CH,
  parameter int unsigned ADDR_W = dsa_pkg::DSA_ADDR_W,
  parameter int unsigned HALF_W = dsa_pkg::DSA_HALF_W,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH*ADDR_W-1:0] live_flat,
  input  logic [NUM_CH-1:0]        area,
  input  logic [CH_W-1:0]          sel_ch,
  input  logic                     sel_hi,
  output logic [HALF_W-1:0]        rdata
);
  localparam int unsigned HI_W  = ADDR_W - HALF_W;
  localparam int unsigned RSV_W = HALF_W - 1 - HI_W;

  logic [ADDR_W-1:0] sel_live;

  always_comb begin
    sel_live = live_flat[sel_ch*ADDR_W +: ADDR_W];
    if (sel_hi) rdata = {area[sel_ch], {RSV_W{1'b0}}, sel_live[ADDR_W-1:HALF_W]};
    else        rdata = sel_live[HALF_W-1:0];
  end
endmodule

// File: rtl/dma_src_addr_bank.sv
module dma_src_addr_bank #(
  parameter int unsigned NUM_CH = dsa_pkg::DSA_NUM_CH,
  parameter int unsigned ADDR_W = dsa_pkg::DSA_ADDR_W,
  parameter int unsigned HALF_W = dsa_pkg::DSA_HALF_W,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_wr,
  input  logic [CH_W-1:0]          cpu_ch,
  input  logic                     cpu_hi,
  input  logic [HALF_W-1:0]        cpu_wdata,
  output logic [HALF_W-1:0]        cpu_rdata,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic [NUM_CH-1:0]        xfer_step,
  input  logic [NUM_CH-1:0]        xfer_wide,
  input  logic [NUM_CH-1:0]        xfer_done,
  output logic [NUM_CH*ADDR_W-1:0] fetch_addr,
  output logic [NUM_CH-1:0]        area_int
);
  localparam int unsigned HI_W = ADDR_W - HALF_W;

  logic [NUM_CH*ADDR_W-1:0] live_flat;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = cpu_wr && (cpu_ch == CH_W'(c));

    dsa_channel #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (hit & ~cpu_hi),
      .wr_hi   (hit & cpu_hi),
      .wdata   (cpu_wdata),
      .en      (ch_en[c]),
      .step    (xfer_step[c]),
      .wide    (xfer_wide[c]),
      .done    (xfer_done[c]),
      .live_o  (live_flat[c*ADDR_W +: ADDR_W]),
      .fetch_o (fetch_addr[c*ADDR_W +: ADDR_W]),
      .area_o  (area_int[c])
    );

    // R6
    wide_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_wide[c] |-> !fetch_addr[c*ADDR_W]);
  end

  dsa_rd_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .HALF_W(HALF_W), .CH_W(CH_W)) u_rd (
    .live_flat (live_flat),
    .area      (area_int),
    .sel_ch    (cpu_ch),
    .sel_hi    (cpu_hi),
    .rdata     (cpu_rdata)
  );

  // R3
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hi |-> cpu_rdata[HALF_W-2:HI_W] == '0);
  // R10
  area_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hi |-> cpu_rdata[HALF_W-1] == area_int[cpu_ch]);
endmodule

// File: tb/dma_src_addr_bank_test.sv
module dma_src_addr_bank_test;
  localparam int NCH = 4;
  localparam int AW  = 26;
  localparam int unsigned MASK = 32'h03FF_FFFF;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cpu_wr, cpu_hi;
  logic [1:0]      cpu_ch;
  logic [15:0]     cpu_wdata, cpu_rdata;
  logic [NCH-1:0]  ch_en, xfer_step, xfer_wide, xfer_done, area_int;
  logic [NCH*AW-1:0] fetch_addr;

  int checks = 0, failures = 0, cyc = 0;
  int unsigned m_live[NCH], m_start[NCH];
  bit m_area[NCH];

  always #4 clk = ~clk;

  dma_src_addr_bank uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_ch(cpu_ch), .cpu_hi(cpu_hi),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ch_en(ch_en), .xfer_step(xfer_step),
    .xfer_wide(xfer_wide), .xfer_done(xfer_done), .fetch_addr(fetch_addr), .area_int(area_int)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, string what, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare, advance the model by one edge, move to the next falling edge
  task automatic tick(string req);
    int unsigned base, exp_rd;
    #1;
    for (int c = 0; c < NCH; c++) begin
      base = xfer_wide[c] ? (m_live[c] & ~32'h1) : m_live[c];
      chk(req, $sformatf("fetch_addr ch%0d", c), 32'(fetch_addr[c*AW +: AW]), base);
      chk(req, $sformatf("area_int ch%0d", c), 32'(area_int[c]), 32'(m_area[c]));
    end
    exp_rd = cpu_hi ? ((32'(m_area[cpu_ch]) << 15) | (m_live[cpu_ch] >> 16))
                    : (m_live[cpu_ch] & 32'hFFFF);
    chk(req, "cpu_rdata", 32'(cpu_rdata), exp_rd);
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (xfer_done[c]) m_live[c] = m_start[c];
        else if (ch_en[c]) begin
          if (xfer_step[c]) begin
            base = xfer_wide[c] ? (m_live[c] & ~32'h1) : m_live[c];
            m_live[c] = (base + (xfer_wide[c] ? 2 : 1)) & MASK;
          end
        end else if (cpu_wr && cpu_ch == 2'(c)) begin
          if (cpu_hi) begin
            m_live[c]  = (m_live[c] & 32'hFFFF) | ((32'(cpu_wdata) & 32'h3FF) << 16);
            m_start[c] = (m_start[c] & 32'hFFFF) | ((32'(cpu_wdata) & 32'h3FF) << 16);
            m_area[c]  = cpu_wdata[15];
          end else begin
            m_live[c]  = (m_live[c] & 32'h3FF_0000) | 32'(cpu_wdata);
            m_start[c] = (m_start[c] & 32'h3FF_0000) | 32'(cpu_wdata);
          end
        end
      end
    end
    @(negedge clk);
    cpu_wr = 1'b0; xfer_step = '0; xfer_done = '0;
  endtask

  task automatic wr(int ch, bit hi, logic [15:0] d, string req);
    cpu_wr = 1'b1; cpu_ch = 2'(ch); cpu_hi = hi; cpu_wdata = d;
    tick(req);
  endtask

  initial begin
    rst_n = 1'b0; cpu_wr = 0; cpu_ch = 0; cpu_hi = 0; cpu_wdata = 0;
    ch_en = 0; xfer_step = 0; xfer_wide = 0; xfer_done = 0;
    for (int c = 0; c < NCH; c++) begin m_live[c] = 0; m_start[c] = 0; m_area[c] = 0; end
    @(negedge clk);
    tick("R1");
    cpu_hi = 1; tick("R1");
    rst_n = 1'b1;
    cpu_hi = 0; tick("R1");

    wr(0, 0, 16'hBEEF, "R2");
    wr(1, 0, 16'h1235, "R2");
    wr(0, 1, 16'hFC2A, "R3");                 // reserved bits set in data, dropped
    cpu_ch = 0; cpu_hi = 1; tick("R3");        // reads 802A
    tick("R10");

    ch_en[0] = 1;
    wr(0, 0, 16'h0000, "R4");
    wr(0, 1, 16'h0155, "R4");
    for (int i = 0; i < 3; i++) begin xfer_step[0] = 1; tick("R5"); end
    cpu_ch = 0; cpu_hi = 0; tick("R8");

    // wrap: ch2 wide at top of space, ch3 byte at top
    wr(2, 1, 16'h03FF, "R5"); wr(2, 0, 16'hFFFE, "R5");
    wr(3, 1, 16'h03FF, "R5"); wr(3, 0, 16'hFFFF, "R5");
    ch_en[3:2] = 2'b11; xfer_wide[2] = 1;
    xfer_step[3:2] = 2'b11; tick("R5");
    tick("R5");

    // odd start, wide transfer
    ch_en[1] = 1; xfer_wide[1] = 1; tick("R6");
    xfer_step[1] = 1; tick("R6");
    cpu_ch = 1; cpu_hi = 0; tick("R8");

    // completion beats a same-cycle step; start survived the blocked writes
    xfer_done[0] = 1; xfer_step[0] = 1; tick("R7");
    ch_en[0] = 0; tick("R7");
    xfer_done[1] = 1; tick("R7");

    // disabled channel ignores steps
    ch_en[3] = 0; xfer_step[3] = 1; tick("R9");
    tick("R9");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) ch_en = 4'($urandom);
      if ($urandom_range(0, 15) == 0) xfer_wide = 4'($urandom);
      xfer_step = 4'($urandom) & 4'($urandom);
      xfer_done = ($urandom_range(0, 19) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'h0;
      cpu_wr = ($urandom_range(0, 2) == 0);
      cpu_ch = 2'($urandom); cpu_hi = 1'($urandom); cpu_wdata = 16'($urandom);
      tick("R9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule